// File: doc/BRIEF.md
# Private Region Filter

Each node of a snoop-coherent multiprocessor holds one copy of this block. It keeps a small set-associative record of memory regions that, as far as this node knows, no other node caches. A region is an aligned block of memory whose size is a power of two. The region tag is every address bit above log2 of the region size. Before the local CPU sends a coherent request onto the interconnect, it presents the address here. If the region is recorded, the request is flagged so that it goes straight to memory with no broadcast snoop.

Entries are written when the combined snoop response for a local request reports that no remote node holds any block of the region. Every snoop request seen from another node is also presented here. When its region is recorded, the record is dropped, so the filter corrects itself once sharing begins. The table has 16 sets of 4 ways by default. The set is selected by the low bits of the region tag, and each way stores the remaining tag bits with a valid bit. Victims are chosen by per-set least-recently-used order.

Top module: `private_region_filter`

## Requirements
- R1: Once reset is released, no region is recorded, `resp_valid` and `skip_snoop` are 0, and any lookup reports `skip_snoop` = 0.
- R2: `resp_valid` is 1 in exactly the cycle after a cycle with `lk_valid` = 1, and is 0 otherwise. `skip_snoop` is never 1 while `resp_valid` is 0.
- R3: A lookup reports `skip_snoop` = 1 exactly when a valid entry holds the lookup's region tag, which is address bits [ADDR_W-1:REGION_LG] (31:14 by default). The offset bits [REGION_LG-1:0] have no effect. The set index is the low log2(SETS) bits of the region tag, which is address bits 17:14 by default.
- R4: A region is recorded only when `rsp_valid` = 1 and `rsp_global_miss` = 1. A response with `rsp_global_miss` = 0 leaves that region unrecorded. A recorded region is visible to a lookup presented in the following cycle.
- R5: A remote request (`rmt_valid` = 1) clears the entry that holds its region. Entries for other regions, in the same set or in other sets, stay valid.
- R6: If a recording and a remote request for the same region arrive in the same cycle, the region is left unrecorded.
- R7: Recording a region that is already present never takes a second way. In a full set, re-recording a present region evicts nothing.
- R8: When a new region is recorded into a full set, the way replaced is the one least recently used. Both a lookup hit and a recording count as a use.
- R9: A lookup in the same cycle as a remote request for the same region reports `skip_snoop` = 0.
- R10: When a set has a free way, a new region is placed there and no valid entry is evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Local CPU lookup request |
| lk_addr | input | ADDR_W | Address of the local request |
| resp_valid | output | 1 | Registered: lookup result is valid |
| skip_snoop | output | 1 | Registered: region is recorded as unshared, so skip the broadcast |
| rsp_valid | input | 1 | Combined snoop response for a local request is present |
| rsp_addr | input | ADDR_W | Address of the request that response belongs to |
| rsp_global_miss | input | 1 | No remote node caches any block of the region |
| rmt_valid | input | 1 | Snoop request from another node is present |
| rmt_addr | input | ADDR_W | Address of the remote snoop request |

## Verification
A lookup's answer is due one clock edge after the request, through the single output register. A recording or a remote invalidation changes the table at the edge that samples it, so it first shows in a lookup presented in the next cycle. Each task drives inputs just after a falling edge and holds them through exactly one rising edge. It then reads `resp_valid` and `skip_snoop` at the next falling edge, when the registered result is settled. The same-cycle races (R6, R9) drive their colliding inputs on the same falling edge. Each set-level case (R7, R8, R10) uses its own set, so the recency order built up by earlier tasks cannot affect it.

// File: rtl/prf_pkg.sv
package prf_pkg;
  // Source of a recency update inside one set
  typedef enum logic [1:0] {
    TOUCH_NONE  = 2'd0,
    TOUCH_ALLOC = 2'd1,
    TOUCH_HIT   = 2'd2
  } touch_src_e;
endpackage

// File: rtl/prf_lru.sv
module prf_lru #(
  parameter int WAYS  = 4,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [WAYS-1:0]  way_vld,
  output logic [WAY_W-1:0] victim
);
  // age 0 = most recent, WAYS-1 = least recent; ages stay a permutation
  logic [WAY_W-1:0] age_q [WAYS];
  logic [WAYS-1:0]  oldest_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= WAY_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WAY_W'(i) == touch_way) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_way]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_old
      assign oldest_v[g] = (age_q[g] == WAY_W'(WAYS - 1));
    end
  endgenerate

  // free way first (lowest index), otherwise the oldest way
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!way_vld[i] && !found) begin
        victim = WAY_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (oldest_v[i]) victim = WAY_W'(i);
      end
    end
  end

  // R8: recency order must keep exactly one least-recent way
  assert_single_oldest_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest_v));
endmodule

// File: rtl/prf_set.sv
module prf_set
  import prf_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int STAG_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_en,
  input  logic [STAG_W-1:0] lk_tag,
  output logic              lk_hit,
  input  logic              al_en,
  input  logic [STAG_W-1:0] al_tag,
  input  logic              rm_en,
  input  logic [STAG_W-1:0] rm_tag
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [STAG_W-1:0] tag_q [WAYS];
  logic [WAYS-1:0]   vld_q;
  logic [WAYS-1:0]   lk_m, al_m, rm_m;
  logic [WAY_W-1:0]  lk_way, al_way, victim, fill_way, touch_way;
  logic              lk_kill, al_kill, al_go, al_dup, al_new;
  touch_src_e        touch_src;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign lk_m[w] = vld_q[w] && (tag_q[w] == lk_tag);
      assign al_m[w] = vld_q[w] && (tag_q[w] == al_tag);
      assign rm_m[w] = vld_q[w] && (tag_q[w] == rm_tag);
    end
  endgenerate

  // a remote request to the same region overrides lookups and recordings
  assign lk_kill = rm_en && (rm_tag == lk_tag);
  assign al_kill = rm_en && (rm_tag == al_tag);
  assign lk_hit  = lk_en && (|lk_m) && !lk_kill;
  assign al_go   = al_en && !al_kill;
  assign al_dup  = |al_m;
  assign al_new  = al_go && !al_dup;

  always_comb begin
    lk_way = '0;
    al_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_m[w]) lk_way = WAY_W'(w);
      if (al_m[w]) al_way = WAY_W'(w);
    end
  end

  assign fill_way = al_dup ? al_way : victim;

  always_comb begin
    if (al_go)       touch_src = TOUCH_ALLOC;
    else if (lk_hit) touch_src = TOUCH_HIT;
    else             touch_src = TOUCH_NONE;
  end

  assign touch_way = (touch_src == TOUCH_ALLOC) ? fill_way : lk_way;

  prf_lru #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (touch_src != TOUCH_NONE),
    .touch_way (touch_way),
    .way_vld   (vld_q),
    .victim    (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (rm_en && rm_m[w]) vld_q[w] <= 1'b0;
      end
      if (al_new) vld_q[fill_way] <= 1'b1;
    end
  end

  // tag storage carries no reset so it can map onto plain RAM bits
  always_ff @(posedge clk) begin
    if (al_new) tag_q[fill_way] <= al_tag;
  end

  // R7: a region never occupies two ways of a set
  assert_no_duplicate_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(al_m) <= 1);

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_chk
      // R4: a way turns valid only because of a recording
      assert_alloc_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(vld_q[w]) |-> $past(al_en));
      // R5: after a remote request, no valid way holds that region
      assert_remote_clears_R5: assert property (@(posedge clk) disable iff (rst)
        rm_en |=> !(vld_q[w] && (tag_q[w] == $past(rm_tag))));
      // R6: a recording racing a remote request to its region leaves nothing
      assert_race_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (al_en && rm_en && (al_tag == rm_tag))
          |=> !(vld_q[w] && (tag_q[w] == $past(al_tag))));
    end
  endgenerate
endmodule

// File: rtl/private_region_filter.sv
module private_region_filter #(
  parameter int ADDR_W    = 32,
  parameter int REGION_LG = 14,
  parameter int SETS      = 16,
  parameter int WAYS      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              resp_valid,
  output logic              skip_snoop,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic              rsp_global_miss,
  input  logic              rmt_valid,
  input  logic [ADDR_W-1:0] rmt_addr
);
  localparam int RTAG_W = ADDR_W - REGION_LG;
  localparam int IDX_W  = $clog2(SETS);
  localparam int STAG_W = RTAG_W - IDX_W;

  logic [RTAG_W-1:0] lk_rt, al_rt, rm_rt;
  logic [SETS-1:0]   set_hit;
  logic              unused_offsets;

  assign lk_rt = lk_addr[ADDR_W-1:REGION_LG];
  assign al_rt = rsp_addr[ADDR_W-1:REGION_LG];
  assign rm_rt = rmt_addr[ADDR_W-1:REGION_LG];
  assign unused_offsets = ^{lk_addr[REGION_LG-1:0], rsp_addr[REGION_LG-1:0],
                            rmt_addr[REGION_LG-1:0]};

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_set
      prf_set #(.WAYS(WAYS), .STAG_W(STAG_W)) u_set (
        .clk    (clk),
        .rst    (rst),
        .lk_en  (lk_valid && (lk_rt[IDX_W-1:0] == IDX_W'(s))),
        .lk_tag (lk_rt[RTAG_W-1:IDX_W]),
        .lk_hit (set_hit[s]),
        .al_en  (rsp_valid && rsp_global_miss && (al_rt[IDX_W-1:0] == IDX_W'(s))),
        .al_tag (al_rt[RTAG_W-1:IDX_W]),
        .rm_en  (rmt_valid && (rm_rt[IDX_W-1:0] == IDX_W'(s))),
        .rm_tag (rm_rt[RTAG_W-1:IDX_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      skip_snoop <= 1'b0;
    end else begin
      resp_valid <= lk_valid;
      skip_snoop <= lk_valid && (|set_hit);
    end
  end

  // R2: result arrives exactly one cycle after the request
  assert_resp_due_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> resp_valid);
  assert_resp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !resp_valid);
  assert_skip_needs_resp_R2: assert property (@(posedge clk) disable iff (rst)
    skip_snoop |-> resp_valid);
endmodule

// File: tb/private_region_filter_bench.sv
module private_region_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        resp_valid, skip_snoop;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_addr = '0;
  logic        rsp_global_miss = 1'b0;
  logic        rmt_valid = 1'b0;
  logic [31:0] rmt_addr = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  private_region_filter u_private_region_filter (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .resp_valid(resp_valid), .skip_snoop(skip_snoop),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_global_miss(rsp_global_miss),
    .rmt_valid(rmt_valid), .rmt_addr(rmt_addr)
  );

  // address from stored tag (bits 31:18), set index (17:14) and offset (13:0)
  function automatic logic [31:0] ad(input int st, input int ix, input int off);
    logic [31:0] a;
    a = {st[13:0], ix[3:0], off[13:0]};
    return a;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic exp, input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " resp_valid"}, resp_valid, 1'b1);
    chk({req, " skip_snoop"}, skip_snoop, exp);
  endtask

  task automatic record(input logic [31:0] a, input logic gm);
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_addr  = a;
    rsp_global_miss = gm;
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_global_miss = 1'b0;
  endtask

  task automatic remote(input logic [31:0] a);
    @(negedge clk);
    rmt_valid = 1'b1;
    rmt_addr  = a;
    @(negedge clk);
    rmt_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 resp_valid after reset", resp_valid, 1'b0);
    chk("R1 skip_snoop after reset", skip_snoop, 1'b0);
    look(ad(3, 1, 0), 1'b0, "R1 empty table");
    @(negedge clk);
    chk("R2 resp_valid drops", resp_valid, 1'b0);
    chk("R2 skip low when idle", skip_snoop, 1'b0);
  endtask

  task automatic t_record_lookup;
    record(ad(5, 2, 0), 1'b0);
    look(ad(5, 2, 0), 1'b0, "R4 shared response ignored");
    record(ad(5, 2, 16), 1'b1);
    look(ad(5, 2, 16383), 1'b1, "R3 other offset same region");
    look(ad(5, 3, 16), 1'b0, "R3 neighbour set");
    look(ad(6, 2, 16), 1'b0, "R3 other upper tag same set");
  endtask

  task automatic t_remote;
    record(ad(10, 4, 0), 1'b1);
    record(ad(11, 4, 0), 1'b1);
    record(ad(10, 5, 0), 1'b1);
    remote(ad(10, 4, 999));
    look(ad(10, 4, 0), 1'b0, "R5 matching region cleared");
    look(ad(11, 4, 0), 1'b1, "R5 same-set region kept");
    look(ad(10, 5, 0), 1'b1, "R5 other-set region kept");
  endtask

  task automatic t_races;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_addr = ad(20, 6, 0); rsp_global_miss = 1'b1;
    rmt_valid = 1'b1; rmt_addr = ad(20, 6, 77);
    @(negedge clk);
    rsp_valid = 1'b0; rsp_global_miss = 1'b0; rmt_valid = 1'b0;
    look(ad(20, 6, 0), 1'b0, "R6 racing record dropped");
    record(ad(21, 6, 0), 1'b1);
    look(ad(21, 6, 0), 1'b1, "R9 region present before race");
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = ad(21, 6, 4);
    rmt_valid = 1'b1; rmt_addr = ad(21, 6, 8);
    @(negedge clk);
    lk_valid = 1'b0; rmt_valid = 1'b0;
    chk("R9 resp_valid", resp_valid, 1'b1);
    chk("R9 racing lookup no skip", skip_snoop, 1'b0);
    look(ad(21, 6, 0), 1'b0, "R9 region gone after race");
  endtask

  task automatic t_dup;
    for (int i = 0; i < 4; i++) record(ad(30 + i, 7, 0), 1'b1);
    record(ad(31, 7, 0), 1'b1);
    for (int i = 0; i < 4; i++) look(ad(30 + i, 7, 0), 1'b1, "R7 full set intact after re-record");
  endtask

  task automatic t_lru;
    for (int i = 0; i < 4; i++) record(ad(40 + i, 8, 0), 1'b1);
    look(ad(40, 8, 0), 1'b1, "R8 refresh oldest");
    record(ad(44, 8, 0), 1'b1);
    look(ad(41, 8, 0), 1'b0, "R8 least recent evicted");
    look(ad(40, 8, 0), 1'b1, "R8 refreshed kept");
    look(ad(42, 8, 0), 1'b1, "R8 kept");
    look(ad(43, 8, 0), 1'b1, "R8 kept");
    look(ad(44, 8, 0), 1'b1, "R8 new entry");
  endtask

  task automatic t_free_way;
    for (int i = 0; i < 4; i++) record(ad(50 + i, 9, 0), 1'b1);
    remote(ad(52, 9, 0));
    record(ad(54, 9, 0), 1'b1);
    look(ad(50, 9, 0), 1'b1, "R10 oldest not evicted");
    look(ad(51, 9, 0), 1'b1, "R10 kept");
    look(ad(53, 9, 0), 1'b1, "R10 kept");
    look(ad(54, 9, 0), 1'b1, "R10 new entry in free way");
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_record_lookup();
    t_remote();
    t_races();
    t_dup();
    t_lru();
    t_free_way();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule